// File: doc/BRIEF.md
# Video Timing-Reference Detector with Range Clipping

This block sits directly behind a parallel video input register and takes one sample per parallel clock. Each sample is first brought to a 10-bit form: in narrow mode an 8-bit byte gets two zero bits appended below its LSB. The word is then clipped, so values at the very bottom and top of the 10-bit range collapse onto the two extremes. The clipped stream is delayed through a short register pipeline toward a downstream scrambler. Every word the scrambler receives has therefore already been clipped.

While the active-low detect enable is held low, a four-state machine watches the clipped stream for the three-word timing reference preamble (all ones, all zeros, all zeros). It treats the following word as the XYZ word and classifies it by its H bit. The output carries a marker over the four reference words and a one-clock start-of-active-video or end-of-active-video pulse aligned with the XYZ word. It also carries a valid-video level that tells the scrambler when picture data is on the bus.

State machine: `S_HUNT` (no preamble seen), `S_ONES` (all-ones word seen), `S_ZERO1` (ones then one zero), `S_ZERO2` (ones then two zeros; the next word is XYZ). Transitions: hunt-to-ones on an all-ones word; ones-to-zero1 and zero1-to-zero2 on an all-zeros word; ones-or-zero1 back to ones on another all-ones word; any other word back to hunt; zero2 always back to hunt after consuming the XYZ word; detect enable high forces hunt from any state.

Top module: `vid_sync_detect`

## Requirements
- R1: Any widened word in the range 000h to 003h is forced to 000h before it enters the pipeline.
- R2: Any widened word in the range 3FCh to 3FFh is forced to 3FFh before it enters the pipeline.
- R3: With `wide_sel` low, the sample is `{in_word[7:0], 2'b00}`; bits 9:8 are ignored. Clipping is then applied, so byte FFh becomes 3FFh. With `wide_sel` high, all ten bits of `in_word` are used.
- R4: A word sampled on rising edge n appears on `out_word` after rising edge n+3 (four register stages).
- R5: A reference is recognised when three consecutive clipped words 3FFh, 000h, 000h are followed by a fourth word, the XYZ word. The XYZ word never starts a new preamble.
- R6: Bit 6 of the clipped XYZ word selects the pulse: 1 gives `eav_pulse`, 0 gives `sav_pulse`. The pulse lasts one clock and is high exactly while the XYZ word is on `out_word`. The two pulses are never high together.
- R7: `trs_mark` is high exactly while any of the four words of a recognised reference is on `out_word`.
- R8: A reference counts only if all four of its words were sampled with `det_en_n` low. A high `det_en_n` returns the machine to `S_HUNT`.
- R9: An internal active flag is cleared on a rising edge with `det_en_n` high, or when `eav_pulse` is high; otherwise it is set when `sav_pulse` is high. `vid_valid` equals this flag while `trs_mark` is low and is 0 while `trs_mark` is high.
- R10: While `rst` is high at a rising edge, the machine returns to `S_HUNT` and all pipeline stages and flags clear, so every output reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| det_en_n | input | 1 | Detection enable, active low |
| wide_sel | input | 1 | 1: 10-bit input, 0: 8-bit input on bits 7:0 |
| in_word | input | 10 | Parallel video sample |
| out_word | output | 10 | Clipped sample, four clocks late |
| trs_mark | output | 1 | High over the four words of a reference |
| sav_pulse | output | 1 | Start-of-active-video XYZ word on the bus |
| eav_pulse | output | 1 | End-of-active-video XYZ word on the bus |
| vid_valid | output | 1 | Active picture data on the bus |

## Verification
The hardest situations to reach are the ones where clipping, rather than the literal input, creates or breaks a preamble. Examples are 3FDh, 002h, 001h followed by an XYZ word, the byte FFh widened to 3FCh in narrow mode, and an all-ones XYZ word followed by two zeros that must not form a second reference. The stimulus builds these sequences directly. It also mixes in whole video lines with random payload near both range ends. An enable pulse is dropped into the middle of a preamble. A reset is applied while the active flag is set. A queue-based behavioural model predicts every output on every clock.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
    localparam int WORD_W   = 10;
    localparam int NARROW_W = 8;
    localparam int TRS_LEN  = 4;
    localparam int H_BIT    = 6;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        S_HUNT,
        S_ONES,
        S_ZERO1,
        S_ZERO2
    } trs_state_t;
endpackage

// File: rtl/vsd_front.sv
module vsd_front
    import vsd_pkg::*;
#(
    parameter int CLIP_SPAN = 4
) (
    input  logic  wide_sel,
    input  word_t raw,
    output word_t clipped
);
    localparam int    PAD    = WORD_W - NARROW_W;
    localparam word_t LO_LIM = word_t'(CLIP_SPAN);
    localparam word_t HI_LIM = word_t'((1 << WORD_W) - 1 - CLIP_SPAN);

    word_t widened;

    always_comb begin
        widened = wide_sel ? raw : {raw[NARROW_W-1:0], {PAD{1'b0}}};
        if (widened < LO_LIM) begin
            clipped = '0;
        end else if (widened > HI_LIM) begin
            clipped = '1;
        end else begin
            clipped = widened;
        end
    end
endmodule

// File: rtl/vsd_trs_fsm.sv
module vsd_trs_fsm
    import vsd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  det_en_n,
    input  word_t cw,
    output logic  xyz_hit
);
    trs_state_t state, state_nx;
    logic is_ones, is_zero;

    assign is_ones = (cw == '1);
    assign is_zero = (cw == '0);

    always_ff @(posedge clk) begin
        if (rst) state <= S_HUNT;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = S_HUNT;
        if (!det_en_n) begin
            unique case (state)
                S_HUNT:  state_nx = is_ones ? S_ONES : S_HUNT;
                S_ONES:  state_nx = is_zero ? S_ZERO1 : (is_ones ? S_ONES : S_HUNT);
                S_ZERO1: state_nx = is_zero ? S_ZERO2 : (is_ones ? S_ONES : S_HUNT);
                S_ZERO2: state_nx = S_HUNT;
            endcase
        end
    end

    always_comb begin
        xyz_hit = (state == S_ZERO2) && !det_en_n;
    end

    // R8: a high enable sends the machine back to hunting
    p_disable_hunt_r8: assert property (@(posedge clk) disable iff (rst)
        det_en_n |=> (state == S_HUNT));

    // R5: the second zero state is only entered from the first
    p_zero_order_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_ZERO2) |-> ($past(state) == S_ZERO1));
endmodule

// File: rtl/vsd_align.sv
module vsd_align
    import vsd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t cw,
    input  logic  xyz_hit,
    output word_t out_word,
    output logic  trs_mark,
    output logic  sav_pulse,
    output logic  eav_pulse
);
    localparam int LAST = TRS_LEN - 1;

    logic [TRS_LEN-1:0][WORD_W-1:0] dpipe;
    logic [TRS_LEN-1:0]             fpipe;
    logic [TRS_LEN-1:0]             hpipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            dpipe <= '0;
            fpipe <= '0;
            hpipe <= '0;
        end else begin
            dpipe <= {dpipe[LAST-1:0], cw};
            fpipe <= {fpipe[LAST-1:0], xyz_hit};
            hpipe <= {hpipe[LAST-1:0], cw[H_BIT]};
        end
    end

    assign out_word  = dpipe[LAST];
    assign trs_mark  = |fpipe;
    assign sav_pulse = fpipe[LAST] & ~hpipe[LAST];
    assign eav_pulse = fpipe[LAST] &  hpipe[LAST];
endmodule

// File: rtl/vid_sync_detect.sv
module vid_sync_detect
    import vsd_pkg::*;
#(
    parameter int CLIP_SPAN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              det_en_n,
    input  logic              wide_sel,
    input  logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] out_word,
    output logic              trs_mark,
    output logic              sav_pulse,
    output logic              eav_pulse,
    output logic              vid_valid
);
    word_t cw;
    logic  xyz_hit;
    logic  active;

    vsd_front #(.CLIP_SPAN(CLIP_SPAN)) u_front (
        .wide_sel (wide_sel),
        .raw      (in_word),
        .clipped  (cw)
    );

    vsd_trs_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .det_en_n (det_en_n),
        .cw       (cw),
        .xyz_hit  (xyz_hit)
    );

    vsd_align u_align (
        .clk       (clk),
        .rst       (rst),
        .cw        (cw),
        .xyz_hit   (xyz_hit),
        .out_word  (out_word),
        .trs_mark  (trs_mark),
        .sav_pulse (sav_pulse),
        .eav_pulse (eav_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst || det_en_n) active <= 1'b0;
        else if (eav_pulse)  active <= 1'b0;
        else if (sav_pulse)  active <= 1'b1;
    end

    assign vid_valid = active & ~trs_mark;

    // R1: nothing just above zero leaves the pipeline
    p_clip_low_r1: assert property (@(posedge clk) disable iff (rst)
        !(out_word inside {10'h001, 10'h002, 10'h003}));

    // R2: nothing just below full scale leaves the pipeline
    p_clip_high_r2: assert property (@(posedge clk) disable iff (rst)
        !(out_word inside {10'h3FC, 10'h3FD, 10'h3FE}));

    // R6: pulse kind matches the H bit of the word on the bus
    p_sav_h_r6: assert property (@(posedge clk) disable iff (rst)
        sav_pulse |-> !out_word[H_BIT]);
    p_eav_h_r6: assert property (@(posedge clk) disable iff (rst)
        eav_pulse |-> out_word[H_BIT]);

    // R6: pulses last one clock
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        (sav_pulse || eav_pulse) |=> !(sav_pulse || eav_pulse));

    // R9: picture data ends with the end-of-active word
    p_eav_ends_valid_r9: assert property (@(posedge clk) disable iff (rst)
        eav_pulse |=> !vid_valid);
endmodule

// File: tb/vid_sync_detect_test.sv
module vid_sync_detect_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       det_en_n = 1'b1;
    logic       wide_sel = 1'b1;
    logic [9:0] in_word = '0;
    logic [9:0] out_word;
    logic       trs_mark, sav_pulse, eav_pulse, vid_valid;

    vid_sync_detect uut (
        .clk(clk), .rst(rst), .det_en_n(det_en_n), .wide_sel(wide_sel),
        .in_word(in_word), .out_word(out_word), .trs_mark(trs_mark),
        .sav_pulse(sav_pulse), .eav_pulse(eav_pulse), .vid_valid(vid_valid)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int cw_h [8192];
    bit en_h [8192];
    bit hb_h [8192];
    bit xyz_h[8192];
    int n = 0;
    bit m_act = 0, prev_s = 0, prev_e = 0;

    task automatic chk(input string req, input int actual, input int expect_v);
        checks++;
        if (actual != expect_v) begin
            fails++;
            $display("FAIL %s at word %0d: actual %0h expected %0h", req, n, actual, expect_v);
        end
    endtask

    // behavioural model of R1..R9, one call per clock
    task automatic step(input int raw, input bit wide, input bit en_n);
        int w, c, exp_out;
        bit hit, mk, es, ee;
        @(negedge clk);
        in_word  = raw[9:0];
        wide_sel = wide;
        det_en_n = en_n;
        w = wide ? (raw & 1023) : ((raw & 255) << 2);      // R3
        c = (w < 4) ? 0 : ((w > 1019) ? 1023 : w);        // R1, R2
        cw_h[n] = c;
        en_h[n] = en_n;
        hb_h[n] = ((c >> 6) & 1) == 1;
        hit = 0;
        if (n >= 3)                                        // R5, R8
            hit = !en_h[n] && !en_h[n-1] && !en_h[n-2] && !en_h[n-3] &&
                  cw_h[n-3] == 1023 && cw_h[n-2] == 0 && cw_h[n-1] == 0 &&
                  !xyz_h[n-3];
        xyz_h[n] = hit;
        @(posedge clk);
        #1;
        exp_out = (n >= 3) ? cw_h[n-3] : 0;
        mk = 0;
        for (int k = 0; k < 4; k++) if (n - k >= 0) mk |= xyz_h[n-k];
        es = (n >= 3) && xyz_h[n-3] && !hb_h[n-3];
        ee = (n >= 3) && xyz_h[n-3] &&  hb_h[n-3];
        if (en_n)        m_act = 0;
        else if (prev_e) m_act = 0;
        else if (prev_s) m_act = 1;
        chk("R4 out_word (clip R1/R2, width R3)", int'(out_word), exp_out);
        chk("R7 trs_mark", int'(trs_mark), int'(mk));
        chk("R6 sav_pulse", int'(sav_pulse), int'(es));
        chk("R6 eav_pulse", int'(eav_pulse), int'(ee));
        chk("R9 vid_valid", int'(vid_valid), int'(m_act && !mk));
        prev_s = es;
        prev_e = ee;
        n++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_word = '0; det_en_n = 1'b1; wide_sel = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R10: everything clear under reset
        chk("R10 out_word", int'(out_word), 0);
        chk("R10 trs_mark", int'(trs_mark), 0);
        chk("R10 sav_pulse", int'(sav_pulse), 0);
        chk("R10 eav_pulse", int'(eav_pulse), 0);
        chk("R10 vid_valid", int'(vid_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        n = 0; m_act = 0; prev_s = 0; prev_e = 0;
    endtask

    task automatic trs(input bit h, input bit wide, input bit en_n);
        if (wide) begin
            step(10'h3FF, 1, en_n); step(0, 1, en_n); step(0, 1, en_n);
            step(h ? 10'h274 : 10'h200, 1, en_n);
        end else begin
            step(8'hFF, 0, en_n); step(0, 0, en_n); step(0, 0, en_n);
            step(h ? 8'h9D : 8'h80, 0, en_n);
        end
    endtask

    task automatic line(input int act_len, input bit wide, input bit en_n);
        trs(1, wide, en_n);
        for (int i = 0; i < 6; i++) step((i % 2) ? 10'h040 : 10'h200, wide, en_n);
        trs(0, wide, en_n);
        for (int i = 0; i < act_len; i++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r == 0)      step($urandom_range(0, 3), wide, en_n);
            else if (r == 1) step($urandom_range(1020, 1023), wide, en_n);
            else             step($urandom_range(4, 1019), wide, en_n);
        end
    endtask

    initial begin
        do_reset();
        det_en_n = 1'b0;
        // main function, 10-bit lines (R5, R6, R7, R9)
        for (int l = 0; l < 4; l++) line(40, 1, 0);
        // R1/R2: clipping builds a preamble from near-extreme values
        step(10'h3FD, 1, 0); step(10'h002, 1, 0); step(10'h001, 1, 0); step(10'h274, 1, 0);
        step(10'h3FC, 1, 0); step(10'h003, 1, 0); step(10'h000, 1, 0); step(10'h200, 1, 0);
        for (int i = 0; i < 5; i++) step(10'h123, 1, 0);
        // R3: narrow mode, upper bits ignored, FFh widened and clipped
        step(10'h3FF, 0, 0); step(10'h300, 0, 0); step(10'h200, 0, 0); step(10'h080, 0, 0);
        for (int l = 0; l < 2; l++) line(30, 0, 0);
        // R5: repeated ones, and an all-ones XYZ must not restart a preamble
        step(10'h3FF, 1, 0); step(10'h3FF, 1, 0); step(0, 1, 0); step(0, 1, 0); step(10'h200, 1, 0);
        step(10'h3FF, 1, 0); step(0, 1, 0); step(0, 1, 0); step(10'h3FF, 1, 0);
        step(0, 1, 0); step(0, 1, 0); step(10'h274, 1, 0);
        for (int i = 0; i < 5; i++) step(10'h155, 1, 0);
        // R8: enable raised in the middle of a preamble, then a whole line disabled
        line(10, 1, 0);
        step(10'h3FF, 1, 0); step(0, 1, 1); step(0, 1, 0); step(10'h274, 1, 0);
        step(10'h3FF, 1, 0); step(0, 1, 0); step(0, 1, 0); step(10'h274, 1, 1);
        line(20, 1, 1);
        line(20, 1, 0);
        // R10: reset while active video is flagged
        trs(0, 1, 0);
        for (int i = 0; i < 6; i++) step(10'h155, 1, 0);
        do_reset();
        det_en_n = 1'b0;
        line(20, 1, 0);
        for (int i = 0; i < 6; i++) step(10'h200, 1, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule